// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block decides when an I2C master may drive a start condition. Software pulses a start-request strobe at any time. If the bus is free, the block issues a start at once and enters a wait state in which it expects the address byte. If the bus is busy, the request is kept as a pending reservation. On the next stop condition seen on the bus (with the stop interrupt enabled), the block starts by itself, in the same cycle as the stop interrupt pulse. A configuration input turns the reservation feature off, so that a request on a busy bus is simply not kept.

The address byte is loaded through a shift-register write strobe. A write counts only while the block is master and waiting for its address. Any write made earlier is discarded, including one made while a reservation waits for the stop. An accepted write hands the byte to the serializer with a one-cycle launch pulse and holds a busy flag until the serializer reports completion. A status-ready output stays low for the minimum settling time after each accepted request. That time is (low width + high width + 4) plus twice the fall time in clock cycles, and software reads the master flag only after it. Line drivers, bit timing and data phases are outside the block.

Top module: `i2c_start_reserve`

## Requirements
- R1: After reset, start_gen, stop_irq, master_sts, resv_pending, wait_state, tx_start, tx_busy and tx_byte are 0 and sts_ready is 1.
- R2: A start request taken while the device is idle (not master, not in extension hold, nothing pending) and bus_busy is 0 makes start_gen 1 for exactly one cycle, starting the next cycle, and sets master_sts and wait_state.
- R3: A start request taken while idle with bus_busy 1 and cfg_resv_dis 0 sets resv_pending on the next cycle, without start_gen and without master_sts.
- R4: With cfg_resv_dis 1, a start request on a busy bus leaves resv_pending at 0, and a later stop produces no start.
- R5: With resv_pending 1, a stop detection while stop_irq_en is 1 gives start_gen, master_sts and wait_state on the next cycle, and resv_pending clears. A stop while stop_irq_en is 0 leaves the reservation pending and issues nothing.
- R6: stop_irq pulses for one cycle, one cycle after each bus_stop_det sampled with stop_irq_en at 1. A stop detection also ends master status.
- R7: An addr_wr is accepted only while wait_state is 1. Then tx_start pulses on the next cycle, tx_byte takes addr_data and wait_state clears. Any other write, including one made while a reservation waits for its stop, leaves tx_byte unchanged and tx_start 0.
- R8: release_req clears a pending reservation on the next cycle. A stop with nothing pending issues no start.
- R9: arb_lost clears master_sts and wait_state. ext_code places the device in a hold in which start requests are ignored, until release_req.
- R10: A start request while master or while a reservation is pending is ignored and does not restart the status timer.
- R11: After an accepted start request, sts_ready is 0 for exactly WAIT cycles, WAIT = LOW_W + HIGH_W + 4 + 2*FALL_CYC (15 with defaults), then returns to 1.
- R12: tx_busy rises together with tx_start and falls the cycle after tx_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_resv_dis | input | 1 | 1 disables start reservation |
| stop_irq_en | input | 1 | Enables the stop-detect interrupt and reserved start |
| start_req | input | 1 | Start request strobe |
| addr_wr | input | 1 | Shift-register write strobe |
| addr_data | input | DATA_W | Byte written to the shift register |
| bus_busy | input | 1 | Bus occupied by some master |
| bus_stop_det | input | 1 | Stop condition detected (one cycle) |
| arb_lost | input | 1 | Arbitration lost (one cycle) |
| ext_code | input | 1 | Extension code received with slave disabled |
| release_req | input | 1 | Bus release command |
| tx_done | input | 1 | Serializer finished the byte |
| start_gen | output | 1 | Start condition issued (one cycle) |
| stop_irq | output | 1 | Stop-detect interrupt pulse |
| master_sts | output | 1 | Device holds master status |
| resv_pending | output | 1 | A reservation is waiting for a stop |
| wait_state | output | 1 | Waiting for the address byte |
| tx_start | output | 1 | Launch pulse to the serializer |
| tx_byte | output | DATA_W | Byte handed to the serializer |
| tx_busy | output | 1 | Serializer owns the byte |
| sts_ready | output | 1 | Settling time since last accepted request elapsed |

## Verification
The start function is driven from a free bus, from a busy bus with reservation on, from a busy bus with reservation off, and from the extension-code hold. These four origins separate an immediate start, a queued start, a dropped request and an ignored request. Stops arrive with the interrupt on and off, with and without a pending reservation, which tells an automatic start apart from a harmless stop. Address writes are placed before the stop, during the wait state and after acceptance, so a design that latches early or repeated writes is caught.

// File: rtl/i2c_resv_pkg.sv
package i2c_resv_pkg;

  // Minimum settling time, in clocks, between a start request and a
  // meaningful read of the master flag.
  function automatic int unsigned min_wait(input int unsigned low_w,
                                           input int unsigned high_w,
                                           input int unsigned fall_cyc);
    return low_w + high_w + 4 + 2 * fall_cyc;
  endfunction

endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_resv_dis,
  input  logic stop_irq_en,
  input  logic start_req,
  input  logic bus_busy,
  input  logic bus_stop_det,
  input  logic arb_lost,
  input  logic ext_code,
  input  logic release_req,
  input  logic addr_taken,
  output logic start_gen,
  output logic stop_irq,
  output logic master_sts,
  output logic resv_pending,
  output logic wait_state,
  output logic evt_accept
);

  logic hold_q;
  logic idle;
  logic go_now;
  logic resv_set;
  logic fire;
  logic issue;

  assign idle       = !master_sts && !hold_q;
  assign evt_accept = start_req && idle && !resv_pending;
  assign go_now     = evt_accept && !bus_busy;
  assign resv_set   = evt_accept && bus_busy && !cfg_resv_dis;
  assign fire       = resv_pending && bus_stop_det && stop_irq_en && idle;
  assign issue      = go_now || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_gen    <= 1'b0;
      stop_irq     <= 1'b0;
      master_sts   <= 1'b0;
      resv_pending <= 1'b0;
      wait_state   <= 1'b0;
      hold_q       <= 1'b0;
    end else begin
      start_gen <= issue;
      stop_irq  <= bus_stop_det && stop_irq_en;

      if (issue)
        master_sts <= 1'b1;
      else if (arb_lost || bus_stop_det || release_req)
        master_sts <= 1'b0;

      if (release_req)
        hold_q <= 1'b0;
      else if (ext_code)
        hold_q <= 1'b1;

      if (release_req || ext_code || fire)
        resv_pending <= 1'b0;
      else if (resv_set)
        resv_pending <= 1'b1;

      if (issue)
        wait_state <= 1'b1;
      else if (addr_taken || arb_lost || bus_stop_det || release_req)
        wait_state <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_gate.sv
module addr_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_state,
  input  logic              addr_wr,
  input  logic [DATA_W-1:0] addr_data,
  input  logic              tx_done,
  output logic              addr_taken,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_busy
);

  assign addr_taken = addr_wr && wait_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_start <= 1'b0;
      tx_byte  <= '0;
      tx_busy  <= 1'b0;
    end else begin
      tx_start <= addr_taken;
      if (addr_taken)
        tx_byte <= addr_data;
      if (addr_taken)
        tx_busy <= 1'b1;
      else if (tx_done)
        tx_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int unsigned WAIT_CYC = 15,
  parameter int unsigned CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CNT_W'(WAIT_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

endmodule

// File: rtl/i2c_start_reserve.sv
module i2c_start_reserve
  import i2c_resv_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_W    = 5,
  parameter int unsigned HIGH_W   = 4,
  parameter int unsigned FALL_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_resv_dis,
  input  logic              stop_irq_en,
  input  logic              start_req,
  input  logic              addr_wr,
  input  logic [DATA_W-1:0] addr_data,
  input  logic              bus_busy,
  input  logic              bus_stop_det,
  input  logic              arb_lost,
  input  logic              ext_code,
  input  logic              release_req,
  input  logic              tx_done,
  output logic              start_gen,
  output logic              stop_irq,
  output logic              master_sts,
  output logic              resv_pending,
  output logic              wait_state,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_busy,
  output logic              sts_ready
);

  localparam int unsigned WAIT_CYC = min_wait(LOW_W, HIGH_W, FALL_CYC);
  localparam int unsigned CNT_W    = $clog2(WAIT_CYC + 1);

  // Internal events, named for the checker.
  logic evt_accept;
  logic evt_addr_taken;

  resv_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_resv_dis (cfg_resv_dis),
    .stop_irq_en  (stop_irq_en),
    .start_req    (start_req),
    .bus_busy     (bus_busy),
    .bus_stop_det (bus_stop_det),
    .arb_lost     (arb_lost),
    .ext_code     (ext_code),
    .release_req  (release_req),
    .addr_taken   (evt_addr_taken),
    .start_gen    (start_gen),
    .stop_irq     (stop_irq),
    .master_sts   (master_sts),
    .resv_pending (resv_pending),
    .wait_state   (wait_state),
    .evt_accept   (evt_accept)
  );

  addr_gate #(.DATA_W(DATA_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_state (wait_state),
    .addr_wr    (addr_wr),
    .addr_data  (addr_data),
    .tx_done    (tx_done),
    .addr_taken (evt_addr_taken),
    .tx_start   (tx_start),
    .tx_byte    (tx_byte),
    .tx_busy    (tx_busy)
  );

  wait_timer #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (evt_accept),
    .ready (sts_ready)
  );

endmodule

// File: rtl/i2c_start_reserve_chk.sv
module i2c_start_reserve_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_resv_dis,
  input logic stop_irq_en,
  input logic addr_wr,
  input logic bus_busy,
  input logic bus_stop_det,
  input logic arb_lost,
  input logic release_req,
  input logic start_gen,
  input logic stop_irq,
  input logic master_sts,
  input logic resv_pending,
  input logic wait_state,
  input logic tx_start
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen |=> !start_gen);  // R2

  AST_START_IS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen |-> master_sts);  // R2

  AST_PENDING_NOT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    resv_pending |-> !master_sts);  // R3

  AST_DISABLED_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_resv_dis && bus_busy && !resv_pending) |=> !resv_pending);  // R4

  AST_RESERVED_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_pending && bus_stop_det && stop_irq_en && !release_req)
      |=> (start_gen && stop_irq && !resv_pending));  // R5

  AST_STOP_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> $past(bus_stop_det && stop_irq_en));  // R6

  AST_TX_ONLY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(wait_state && addr_wr));  // R7

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> !resv_pending);  // R8

  AST_ARB_LOST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && master_sts) |=> (!master_sts && !wait_state));  // R9

endmodule

bind i2c_start_reserve i2c_start_reserve_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_resv_dis (cfg_resv_dis),
  .stop_irq_en  (stop_irq_en),
  .addr_wr      (addr_wr),
  .bus_busy     (bus_busy),
  .bus_stop_det (bus_stop_det),
  .arb_lost     (arb_lost),
  .release_req  (release_req),
  .start_gen    (start_gen),
  .stop_irq     (stop_irq),
  .master_sts   (master_sts),
  .resv_pending (resv_pending),
  .wait_state   (wait_state),
  .tx_start     (tx_start)
);

// File: tb/i2c_start_reserve_bench.sv
`timescale 1ns/1ps
module i2c_start_reserve_bench;

  localparam int LOW_W = 5, HIGH_W = 4, FALL_CYC = 1;
  localparam int WAIT = LOW_W + HIGH_W + 4 + FALL_CYC * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_resv_dis = 0, stop_irq_en = 0, start_req = 0, addr_wr = 0;
  logic [7:0] addr_data = 8'h00;
  logic bus_busy = 0, bus_stop_det = 0, arb_lost = 0, ext_code = 0;
  logic release_req = 0, tx_done = 0;
  logic start_gen, stop_irq, master_sts, resv_pending, wait_state;
  logic tx_start, tx_busy, sts_ready;
  logic [7:0] tx_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_start_reserve #(.DATA_W(8), .LOW_W(LOW_W), .HIGH_W(HIGH_W), .FALL_CYC(FALL_CYC))
  u_i2c_start_reserve (
    .clk(clk), .rst_n(rst_n), .cfg_resv_dis(cfg_resv_dis), .stop_irq_en(stop_irq_en),
    .start_req(start_req), .addr_wr(addr_wr), .addr_data(addr_data), .bus_busy(bus_busy),
    .bus_stop_det(bus_stop_det), .arb_lost(arb_lost), .ext_code(ext_code),
    .release_req(release_req), .tx_done(tx_done), .start_gen(start_gen),
    .stop_irq(stop_irq), .master_sts(master_sts), .resv_pending(resv_pending),
    .wait_state(wait_state), .tx_start(tx_start), .tx_byte(tx_byte),
    .tx_busy(tx_busy), .sts_ready(sts_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Behavioural reference: a role word plus a queue holding the reservation.
  int  m_role;            // 0 idle, 1 master, 2 extension hold
  bit  m_resv[$];
  bit  m_wait, m_start, m_irq, m_txs, m_busy;
  int  m_byte, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_role = 0; m_resv.delete(); m_wait = 0; m_start = 0; m_irq = 0;
      m_txs = 0; m_busy = 0; m_byte = 0; m_cnt = 0;
    end else begin
      bit free_role, took, fired, got_addr, launched;
      free_role = (m_role == 0);
      took      = start_req && free_role && (m_resv.size() == 0);
      fired     = (m_resv.size() != 0) && bus_stop_det && stop_irq_en && free_role;
      got_addr  = addr_wr && m_wait;
      launched  = (took && !bus_busy) || fired;
      m_start = launched;
      m_irq   = bus_stop_det && stop_irq_en;
      m_txs   = got_addr;
      if (got_addr) m_byte = addr_data;
      if (got_addr) m_busy = 1; else if (tx_done) m_busy = 0;
      if (launched) m_wait = 1;
      else if (got_addr || arb_lost || bus_stop_det || release_req) m_wait = 0;
      if (took) m_cnt = WAIT; else if (m_cnt > 0) m_cnt--;
      if (release_req || ext_code || fired) m_resv.delete();
      else if (took && bus_busy && !cfg_resv_dis) m_resv.push_back(1'b1);
      if (launched) m_role = 1;
      else if (release_req) m_role = 0;
      else if (m_role == 1 && (arb_lost || bus_stop_det)) m_role = ext_code ? 2 : 0;
      else if (ext_code) m_role = 2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      eq("R2 model start_gen", start_gen, m_start);
      eq("R6 model stop_irq", stop_irq, m_irq);
      eq("R9 model master_sts", master_sts, m_role == 1);
      eq("R3 model resv_pending", resv_pending, m_resv.size() != 0);
      eq("R7 model wait_state", wait_state, m_wait);
      eq("R7 model tx_start", tx_start, m_txs);
      eq("R7 model tx_byte", tx_byte, m_byte);
      eq("R12 model tx_busy", tx_busy, m_busy);
      eq("R11 model sts_ready", sts_ready, m_cnt == 0);
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    start_req = 0; addr_wr = 0; bus_stop_det = 0; arb_lost = 0;
    ext_code = 0; release_req = 0; tx_done = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    eq("R1 start_gen", start_gen, 0);
    eq("R1 master_sts", master_sts, 0);
    eq("R1 resv_pending", resv_pending, 0);
    eq("R1 tx_byte", tx_byte, 0);
    eq("R1 sts_ready", sts_ready, 1);
    rst_n = 1;
    cyc();

    // Immediate start on a free bus (R2, R11, R10)
    start_req = 1; cyc();
    eq("R2 start_gen", start_gen, 1);
    eq("R2 master_sts", master_sts, 1);
    eq("R2 wait_state", wait_state, 1);
    eq("R11 sts_ready low", sts_ready, 0);
    begin
      int k = 0;
      while (!sts_ready && k < 100) begin cyc(); k++; end
      eq("R11 wait length", k, WAIT);
    end
    start_req = 1; cyc();
    eq("R10 start ignored while master", start_gen, 0);
    eq("R10 timer not restarted", sts_ready, 1);
    addr_wr = 1; addr_data = 8'hA5; cyc();
    eq("R7 tx_start", tx_start, 1);
    eq("R7 tx_byte", tx_byte, 8'hA5);
    eq("R12 tx_busy set", tx_busy, 1);
    addr_wr = 1; addr_data = 8'h77; cyc();
    eq("R7 second write dropped", tx_byte, 8'hA5);
    tx_done = 1; cyc();
    eq("R12 tx_busy cleared", tx_busy, 0);
    bus_stop_det = 1; cyc();
    eq("R6 stop ends master", master_sts, 0);
    eq("R6 no irq when disabled", stop_irq, 0);

    // Reservation on a busy bus (R3, R5, R7)
    bus_busy = 1; stop_irq_en = 1;
    start_req = 1; cyc();
    eq("R3 pending", resv_pending, 1);
    eq("R3 no start", start_gen, 0);
    addr_wr = 1; addr_data = 8'h3C; cyc();
    eq("R7 early write dropped", tx_byte, 8'hA5);
    eq("R7 no launch", tx_start, 0);
    bus_stop_det = 1; cyc();
    eq("R5 reserved start", start_gen, 1);
    eq("R5 irq same cycle", stop_irq, 1);
    eq("R5 pending cleared", resv_pending, 0);
    cyc();
    eq("R6 irq one cycle", stop_irq, 0);
    addr_wr = 1; addr_data = 8'h5A; cyc();
    eq("R7 late write taken", tx_byte, 8'h5A);
    tx_done = 1; cyc();
    bus_stop_det = 1; cyc();
    eq("R8 stop without reservation", start_gen, 0);

    // Reservation disabled (R4)
    cfg_resv_dis = 1;
    start_req = 1; cyc();
    eq("R4 not queued", resv_pending, 0);
    bus_stop_det = 1; cyc();
    eq("R4 no start after stop", start_gen, 0);
    cfg_resv_dis = 0;

    // Release drops reservation (R8)
    start_req = 1; cyc();
    release_req = 1; cyc();
    eq("R8 release clears", resv_pending, 0);
    bus_stop_det = 1; cyc();
    eq("R8 no start", start_gen, 0);

    // Stop with interrupt off keeps the reservation (R5), arb lost (R9)
    stop_irq_en = 0;
    start_req = 1; cyc();
    bus_stop_det = 1; cyc();
    eq("R5 no fire without irq", start_gen, 0);
    eq("R5 still pending", resv_pending, 1);
    stop_irq_en = 1;
    bus_stop_det = 1; cyc();
    eq("R5 fire with irq", start_gen, 1);
    arb_lost = 1; cyc();
    eq("R9 arb lost master", master_sts, 0);
    eq("R9 arb lost wait", wait_state, 0);

    // Extension-code hold (R9)
    bus_busy = 0;
    ext_code = 1; cyc();
    start_req = 1; cyc();
    eq("R9 start ignored in hold", start_gen, 0);
    release_req = 1; cyc();
    start_req = 1; cyc();
    eq("R9 start after release", start_gen, 1);
    release_req = 1; cyc();
    eq("R9 release ends master", master_sts, 0);

    repeat (3) cyc();
    finish_run();
  end

endmodule